// File: doc/BRIEF.md
# Classification Result Queue with Silence Coalescing

This block sits behind a small classifier network and receives one finished inference result per pass. Each result carries the winning output neuron's ID and value, the two speaker-gender neuron values, and the values of the twenty user-identification neurons. The block turns that result into a 5-byte record and decides whether the record goes into a shallow FIFO. Records whose winning value is below a confidence threshold are discarded.

Silence results get special treatment. Inter-word silence has ID 0x02 and inter-sentence silence has ID 0x03. A silence record is queued only while the FIFO holds no speech (non-silence) records. A sentence silence that follows a queued word silence overwrites that word silence in place. A word-ready output tells the host that a complete utterance is waiting: it combines the latest silence detection with the presence of speech records. The host pops the oldest record, reads the record count, and can flush the queue. A sticky flag reports records lost to a full queue.

Top module: `result_queue`

## Requirements
- R1: After reset, `count` is 0, `head` is all zeros, and `word_ready` and `overflow` are 0.
- R2: A result is queued only when `res_val` is at least THRESH (default 204). `count` rises by one on the clock edge that samples a qualifying `res_valid`.
- R3: The queued record is laid out as `head[39:32]` winning ID, `[31:24]` winning value, `[23:16]` female value, `[15:8]` male value, `[7:0]` user ID.
- R4: User neuron k is `res_users[8k+7:8k]`, with k from 0 to 19. The user ID is k+1 for the lowest k whose value is at least THRESH, and 0 when no user neuron reaches THRESH.
- R5: `head` shows the oldest record. A `pop` strobe removes it. When the queue is empty, `head` reads all zeros and a `pop` changes nothing.
- R6: While the queue holds DEPTH records, a newly admitted record is dropped and `overflow` is set until `clear`. A `pop` in the same cycle frees a slot first, so the record is accepted.
- R7: A qualifying silence result (ID 0x02 or 0x03) is not queued while any speech record is in the queue.
- R8: If the newest record is a word silence (0x02) and a qualifying sentence silence (0x03) arrives, that record is overwritten and `count` does not change.
- R9: `word_ready` is 1 exactly when the latest `res_valid` result was a qualifying silence and the queue holds at least one speech record.
- R10: `clear` empties the queue and clears `overflow` on the next edge. It takes priority over a `pop` or result in the same cycle.

Note: DEPTH must be a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | One-cycle strobe marking a finished inference result |
| res_id | input | 8 | Winning output neuron ID |
| res_val | input | 8 | Winning output neuron value |
| res_female | input | 8 | Female speaker neuron value |
| res_male | input | 8 | Male speaker neuron value |
| res_users | input | 8*N_USERS | User-identification neuron values, neuron k in bits 8k+7:8k |
| pop | input | 1 | Remove the oldest record |
| clear | input | 1 | Empty the queue and clear the overflow flag |
| head | output | 40 | Oldest record, zero when empty |
| count | output | $clog2(DEPTH+1) | Number of queued records |
| word_ready | output | 1 | Silence detected while speech records are queued |
| overflow | output | 1 | Sticky: a record was dropped because the queue was full |

## Verification
The bench builds the queue with DEPTH set to 4, while THRESH and N_USERS keep their defaults. The small depth brings the full-queue cases within reach in a handful of results: the dropped record, the sticky overflow flag, and a pop that frees a slot in the same cycle as a push. Keeping the default threshold and user count means the 203/204 boundary and the lowest-index user selection across all twenty user neurons are exercised exactly as configured.

// File: rtl/result_queue.sv
module result_queue #(
  parameter int DEPTH   = 16,
  parameter int N_USERS = 20,
  parameter int THRESH  = 204,
  parameter logic [7:0] WORD_SIL_ID = 8'h02,
  parameter logic [7:0] SENT_SIL_ID = 8'h03
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       res_valid,
  input  logic [7:0]                 res_id,
  input  logic [7:0]                 res_val,
  input  logic [7:0]                 res_female,
  input  logic [7:0]                 res_male,
  input  logic [8*N_USERS-1:0]       res_users,
  input  logic                       pop,
  input  logic                       clear,
  output logic [39:0]                head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       word_ready,
  output logic                       overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [7:0] TH = 8'(THRESH);

  logic [39:0]   mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr, tail_ptr;
  logic [CW-1:0] cnt, speech, cnt_p, speech_p;
  logic          sil_active;
  logic [7:0]    uid;

  function automatic logic is_sil(input logic [7:0] id);
    return id == WORD_SIL_ID || id == SENT_SIL_ID;
  endfunction

  always_comb begin
    uid = '0;
    for (int k = N_USERS-1; k >= 0; k--)
      if (res_users[8*k +: 8] >= TH) uid = 8'(k+1);
  end

  wire        pop_eff  = pop && cnt != '0;
  wire        head_sil = is_sil(mem[rd_ptr][39:32]);
  wire        hit      = res_valid && res_val >= TH;
  wire        new_sil  = is_sil(res_id);
  wire [39:0] entry    = {res_id, res_val, res_female, res_male, uid};

  assign tail_ptr = wr_ptr - AW'(1);
  assign cnt_p    = cnt - CW'(pop_eff);
  assign speech_p = speech - CW'(pop_eff && !head_sil);

  wire replace = hit && res_id == SENT_SIL_ID && cnt_p != '0 &&
                 mem[tail_ptr][39:32] == WORD_SIL_ID && speech_p == '0;
  wire admit   = hit && !replace && (!new_sil || speech_p == '0);
  wire push    = admit && cnt_p < CW'(DEPTH);
  wire drop    = admit && cnt_p == CW'(DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      speech     <= '0;
      rd_ptr     <= '0;
      wr_ptr     <= '0;
      overflow   <= 1'b0;
      sil_active <= 1'b0;
    end else begin
      if (res_valid) sil_active <= hit && new_sil;
      if (clear) begin
        cnt      <= '0;
        speech   <= '0;
        rd_ptr   <= '0;
        wr_ptr   <= '0;
        overflow <= 1'b0;
      end else begin
        cnt    <= cnt_p + CW'(push);
        speech <= speech_p + CW'(push && !new_sil);
        rd_ptr <= rd_ptr + AW'(pop_eff);
        wr_ptr <= wr_ptr + AW'(push);
        if (drop) overflow <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!clear) begin
      if (push)         mem[wr_ptr]   <= entry;
      else if (replace) mem[tail_ptr] <= entry;
    end
  end

  assign head       = (cnt != '0) ? mem[rd_ptr] : 40'd0;
  assign count      = cnt;
  assign word_ready = sil_active && speech != '0;
endmodule

module result_queue_checker #(
  parameter int DEPTH  = 16,
  parameter int THRESH = 204
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       res_valid,
  input logic [7:0]                 res_val,
  input logic                       pop,
  input logic                       clear,
  input logic [39:0]                head,
  input logic [$clog2(DEPTH+1)-1:0] count,
  input logic                       word_ready,
  input logic                       overflow
);
  localparam int CW = $clog2(DEPTH+1);

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  p_overflow_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !clear |=> overflow);
  p_empty_head_r5: assert property (@(posedge clk) disable iff (!rst_n)
    count == '0 |-> head == 40'd0);
  p_pop_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop && count == '0 && !res_valid && !clear |=> count == '0);
  p_low_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_val < 8'(THRESH) && !pop && !clear |=> $stable(count));
  p_ready_needs_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> count != '0);
  p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> count == '0 && !overflow);
endmodule

bind result_queue result_queue_checker #(.DEPTH(DEPTH), .THRESH(THRESH)) u_chk (
  .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_val(res_val),
  .pop(pop), .clear(clear), .head(head), .count(count),
  .word_ready(word_ready), .overflow(overflow)
);

// File: tb/result_queue_bench.sv
module result_queue_bench;
  localparam int DEPTH = 4;
  localparam int NU    = 20;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          res_valid = 1'b0, pop = 1'b0, clear = 1'b0;
  logic [7:0]    res_id = '0, res_val = '0, res_female = '0, res_male = '0;
  logic [8*NU-1:0] res_users = '0;
  logic [39:0]   head;
  logic [2:0]    count;
  logic          word_ready, overflow;
  int            n_checks = 0, n_fail = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  result_queue #(.DEPTH(DEPTH)) u_result_queue (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_id(res_id),
    .res_val(res_val), .res_female(res_female), .res_male(res_male),
    .res_users(res_users), .pop(pop), .clear(clear), .head(head),
    .count(count), .word_ready(word_ready), .overflow(overflow));

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [8*NU-1:0] users(input int a, input int b);
    logic [8*NU-1:0] u;
    for (int k = 0; k < NU; k++) u[8*k +: 8] = 8'd10;
    if (a >= 0) u[8*a +: 8] = 8'd210;
    if (b >= 0) u[8*b +: 8] = 8'd204;
    return u;
  endfunction

  task automatic send(input logic [7:0] id, input logic [7:0] v, input logic [8*NU-1:0] u,
                      input bit with_pop = 1'b0, input bit with_clear = 1'b0);
    res_valid = 1'b1; res_id = id; res_val = v;
    res_female = 8'h5A; res_male = 8'hA5; res_users = u;
    pop = with_pop; clear = with_clear;
    @(negedge clk);
    res_valid = 1'b0; pop = 1'b0; clear = 1'b0;
  endtask

  task automatic do_pop();
    pop = 1'b1; @(negedge clk); pop = 1'b0;
  endtask

  task automatic do_clear();
    clear = 1'b1; @(negedge clk); clear = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 count", 40'(count), 40'd0);
    check("R1 head", head, 40'd0);
    check("R1 word_ready", 40'(word_ready), 40'd0);
    check("R1 overflow", 40'(overflow), 40'd0);
  endtask

  task automatic t_threshold();
    do_clear();
    send(8'h10, 8'd203, users(-1, -1));
    check("R2 below threshold", 40'(count), 40'd0);
    send(8'h10, 8'd204, users(-1, -1));
    check("R2 at threshold", 40'(count), 40'd1);
    check("R3 layout", head, {8'h10, 8'd204, 8'h5A, 8'hA5, 8'h00});
  endtask

  task automatic t_user();
    do_clear();
    send(8'h20, 8'd250, users(7, 3));
    send(8'h21, 8'd250, users(19, -1));
    send(8'h22, 8'd250, users(0, 12));
    check("R4 lowest user", 40'(head[7:0]), 40'd4);
    do_pop();
    check("R4 last user", 40'(head[7:0]), 40'd20);
    do_pop();
    check("R4 first user", 40'(head[7:0]), 40'd1);
    do_clear();
    send(8'h23, 8'd250, users(-1, -1));
    check("R4 no user", 40'(head[7:0]), 40'd0);
  endtask

  task automatic t_order();
    do_clear();
    send(8'h30, 8'd220, users(-1, -1));
    send(8'h31, 8'd221, users(-1, -1));
    check("R5 oldest first", 40'(head[39:32]), 40'h30);
    do_pop();
    check("R5 pop advances", 40'(head[39:32]), 40'h31);
    check("R5 count after pop", 40'(count), 40'd1);
    do_pop();
    check("R5 empty head", head, 40'd0);
    do_pop();
    check("R5 pop empty count", 40'(count), 40'd0);
    check("R5 pop empty head", head, 40'd0);
  endtask

  task automatic t_full();
    do_clear();
    for (int i = 0; i < DEPTH; i++) send(8'(8'h40 + i), 8'd230, users(-1, -1));
    check("R6 filled", 40'(count), 40'(DEPTH));
    check("R6 no overflow yet", 40'(overflow), 40'd0);
    send(8'h4F, 8'd230, users(-1, -1));
    check("R6 drop count", 40'(count), 40'(DEPTH));
    check("R6 overflow set", 40'(overflow), 40'd1);
    check("R6 head kept", 40'(head[39:32]), 40'h40);
    send(8'h50, 8'd230, users(-1, -1), 1'b1);
    check("R6 pop+push count", 40'(count), 40'(DEPTH));
    check("R6 pop+push head", 40'(head[39:32]), 40'h41);
    check("R6 overflow sticky", 40'(overflow), 40'd1);
    for (int i = 0; i < DEPTH - 1; i++) do_pop();
    check("R6 new tail", 40'(head[39:32]), 40'h50);
    send(8'h60, 8'd230, users(-1, -1), 1'b1, 1'b1);
    check("R10 clear wins count", 40'(count), 40'd0);
    check("R10 clear overflow", 40'(overflow), 40'd0);
  endtask

  task automatic t_silence();
    do_clear();
    send(8'h02, 8'd220, users(-1, -1));
    check("R8 word sil queued", 40'(count), 40'd1);
    send(8'h03, 8'd225, users(-1, -1));
    check("R8 replace count", 40'(count), 40'd1);
    check("R8 replace head", 40'(head[39:24]), 40'h03E1);
    send(8'h02, 8'd220, users(-1, -1));
    check("R8 word after sentence appends", 40'(count), 40'd2);
    send(8'h25, 8'd240, users(-1, -1));
    check("R9 no silence yet", 40'(word_ready), 40'd0);
    send(8'h03, 8'd230, users(-1, -1));
    check("R7 silence rejected", 40'(count), 40'd3);
    check("R9 ready", 40'(word_ready), 40'd1);
    send(8'h02, 8'd100, users(-1, -1));
    check("R9 weak silence", 40'(word_ready), 40'd0);
    send(8'h02, 8'd220, users(-1, -1));
    check("R7 word silence rejected", 40'(count), 40'd3);
    check("R9 ready again", 40'(word_ready), 40'd1);
    do_pop();
    do_pop();
    check("R9 speech remains", 40'(word_ready), 40'd1);
    do_pop();
    check("R9 no speech", 40'(word_ready), 40'd0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold();
    t_user();
    t_order();
    t_full();
    t_silence();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end
endmodule